// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block drives one active-high system reset from three causes. The first is a power-on reset, taken from the synchronous `rst` input. The second is a supply-low indication that an external comparator has already turned into a digital level. The third is expiry of a watchdog timer. Each cause holds the reset output for its own number of clock cycles before the system may run again:

- the power-on stretch covers supply and oscillator settling;
- the low-supply settle period starts when the supply indication clears;
- the watchdog pulse is a short fixed width.

While the reset output is low, a prescaler produces timebase ticks and the watchdog counts those ticks. A two-bit select picks one of three preset timeouts or turns the watchdog off. The host keeps the system alive by toggling its active-low chip-select line. That line also serves as the watchdog input. After a two-stage synchronizer, each falling edge on it restarts both the prescaler and the watchdog count.

A volatile flag records that a watchdog expiry caused a reset, so software can tell it apart from a supply-low reset. Explicit set and clear commands also drive the flag. Power-on reset clears it.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst` is high, `reset_out` is 1 and `wd_flag` is 0. After `rst` falls, `reset_out` stays 1 for exactly `POR_HOLD` rising clock edges and then drops to 0.
- R2: With `reset_out` low, the watchdog asserts `reset_out` after exactly `TMO_x * TICK_DIV` cycles without a restart. The select `wd_sel` encodes the timeout as follows: 2'b00 selects `TMO_SHORT`, 2'b01 selects `TMO_MED` and 2'b10 selects `TMO_LONG`.
- R3: A watchdog expiry holds `reset_out` at 1 for exactly `WD_PULSE` cycles. After that the output returns to 0 and the watchdog runs again.
- R4: `supply_low` = 1 sampled at a clock edge makes `reset_out` 1 after that edge, and the output stays 1 while `supply_low` remains high. After `supply_low` returns to 0, the output stays 1 for exactly `LV_SETTLE` more edges.
- R5: `wd_sel` = 2'b11 disables the watchdog, so no expiry occurs however long the line stays idle. Selecting a timeout again re-arms the watchdog.
- R6: A falling edge on `cs_wdi_n` restarts the watchdog interval after the two-stage synchronizer. A rising edge alone does not restart it.
- R7: While `reset_out` is 1, the watchdog count is held at zero, so every release from reset begins a full interval.
- R8: A watchdog expiry sets `wd_flag` to 1. A supply-low reset leaves `wd_flag` unchanged.
- R9: `flag_set` sets `wd_flag` and `flag_clr` clears it at the next edge. When both are high in the same cycle, set wins. A watchdog expiry wins over a simultaneous `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low | input | 1 | Supply-below-threshold indication, already digital |
| wd_sel | input | 2 | Watchdog timeout select (11 = off) |
| cs_wdi_n | input | 1 | Active-low chip select, doubling as watchdog input |
| flag_set | input | 1 | Command: set the watchdog-cause flag |
| flag_clr | input | 1 | Command: clear the watchdog-cause flag |
| reset_out | output | 1 | Active-high system reset |
| wd_flag | output | 1 | Last-reset-was-watchdog flag |

## Verification
The bound checker watches several relations on every cycle:
- reset is forced during power-on and supply-low conditions;
- an expiry always raises both the reset and the flag;
- the off setting never yields an expiry;
- the watchdog count is zero after any reset cycle;
- the flag moves only on a command or an expiry.

Exact cycle counts can be shown only by the bench scenarios, which measure them at the ports. These counts are the power-on stretch, the settle period, the pulse width and each of the three timeouts. The scenarios also show that rising edges on the chip-select line do not restart the timer, that periodic falling edges keep the system alive, and how the flag commands take priority over one another.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    // Cause of the current reset stretch, or normal running
    typedef enum logic [1:0] {
        HS_POR  = 2'b00,
        HS_LOWV = 2'b01,
        HS_WDOG = 2'b10,
        HS_RUN  = 2'b11
    } hold_src_e;

    // Watchdog timeout select encoding
    typedef enum logic [1:0] {
        WSEL_SHORT = 2'b00,
        WSEL_MED   = 2'b01,
        WSEL_LONG  = 2'b10,
        WSEL_OFF   = 2'b11
    } wd_sel_e;

    // Events acting on the cause flag
    typedef struct packed {
        logic wd_hit;
        logic set;
        logic clr;
    } flag_ev_t;

    // Timeout in ticks for a select value; off returns 1 (unused)
    function automatic int unsigned tmo_ticks(input wd_sel_e sel,
                                              input int unsigned t_s,
                                              input int unsigned t_m,
                                              input int unsigned t_l);
        case (sel)
            WSEL_SHORT: return t_s;
            WSEL_MED:   return t_m;
            WSEL_LONG:  return t_l;
            default:    return 1;
        endcase
    endfunction

    // Hold length in cycles for a given reset cause
    function automatic int unsigned hold_cycles(input hold_src_e src,
                                                input int unsigned por,
                                                input int unsigned lv,
                                                input int unsigned wd);
        case (src)
            HS_POR:  return por;
            HS_LOWV: return lv;
            HS_WDOG: return wd;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_rst_edge_sync.sv
module sup_rst_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain_q[STAGES-1];
    end

    // Falling edge of the synchronized level
    assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sup_rst_timebase.sv
module sup_rst_timebase #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PC_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pc_q;
    logic          at_last;

    assign at_last = (pc_q == PC_LAST);
    assign tick_o  = run_i & ~clr_i & at_last;

    always_ff @(posedge clk) begin
        if (rst || !run_i || clr_i) pc_q <= '0;
        else if (at_last)           pc_q <= '0;
        else                        pc_q <= pc_q + 1'b1;
    end

endmodule

// File: rtl/sup_rst_wdog.sv
module sup_rst_wdog
    import sup_rst_pkg::*;
#(
    parameter int TMO_SHORT = 8,
    parameter int TMO_MED   = 16,
    parameter int TMO_LONG  = 32,
    parameter int CW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          kick_i,
    input  logic          tick_i,
    input  logic [1:0]    sel_i,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);
    wd_sel_e       sel;
    logic          enabled;
    logic [CW-1:0] lim_m1;
    logic [CW-1:0] cnt_q;

    assign sel     = wd_sel_e'(sel_i);
    assign enabled = (sel != WSEL_OFF);

    always_comb begin
        lim_m1 = CW'(tmo_ticks(sel, TMO_SHORT, TMO_MED, TMO_LONG) - 1);
    end

    // >= so a shortened select mid-interval still expires
    assign expire_o = run_i & enabled & ~kick_i & tick_i & (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || !run_i || kick_i || !enabled) cnt_q <= '0;
        else if (expire_o)                       cnt_q <= '0;
        else if (tick_i)                         cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sup_rst_hold_ctrl.sv
module sup_rst_hold_ctrl
    import sup_rst_pkg::*;
#(
    parameter int POR_HOLD  = 24,
    parameter int LV_SETTLE = 16,
    parameter int WD_PULSE  = 6,
    parameter int HW        = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     supply_low_i,
    input  flag_ev_t ev_i,
    output logic     run_o,
    output logic     flag_o
);
    hold_src_e     src_q;
    logic [HW-1:0] hc_q;
    logic [HW-1:0] hc_last;
    logic          flag_q;

    always_comb begin
        hc_last = HW'(hold_cycles(src_q, POR_HOLD, LV_SETTLE, WD_PULSE) - 1);
    end

    // Supply-low overrides any other cause; hold counts from each release
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= HS_POR;
            hc_q  <= '0;
        end else if (supply_low_i) begin
            src_q <= HS_LOWV;
            hc_q  <= '0;
        end else if (src_q == HS_RUN) begin
            if (ev_i.wd_hit) begin
                src_q <= HS_WDOG;
                hc_q  <= '0;
            end
        end else if (hc_q == hc_last) begin
            src_q <= HS_RUN;
            hc_q  <= '0;
        end else begin
            hc_q <= hc_q + 1'b1;
        end
    end

    // Priority: expiry, then set, then clear
    always_ff @(posedge clk) begin
        if (rst)               flag_q <= 1'b0;
        else if (ev_i.wd_hit)  flag_q <= 1'b1;
        else if (ev_i.set)     flag_q <= 1'b1;
        else if (ev_i.clr)     flag_q <= 1'b0;
    end

    assign run_o  = (src_q == HS_RUN);
    assign flag_o = flag_q;

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_rst_pkg::*;
#(
    parameter int POR_HOLD    = 24,
    parameter int LV_SETTLE   = 16,
    parameter int WD_PULSE    = 6,
    parameter int TICK_DIV    = 4,
    parameter int TMO_SHORT   = 8,
    parameter int TMO_MED     = 16,
    parameter int TMO_LONG    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low,
    input  logic [1:0] wd_sel,
    input  logic       cs_wdi_n,
    input  logic       flag_set,
    input  logic       flag_clr,
    output logic       reset_out,
    output logic       wd_flag
);
    localparam int TMO_MAX = int'(max3(TMO_SHORT, TMO_MED, TMO_LONG));
    localparam int HLD_MAX = int'(max3(POR_HOLD, LV_SETTLE, WD_PULSE));
    localparam int CNT_W   = $clog2(TMO_MAX + 1);
    localparam int HLD_W   = $clog2(HLD_MAX + 1);

    logic             kick;
    logic             tick;
    logic             running;
    logic             wd_expire;
    logic [CNT_W-1:0] wd_cnt;
    flag_ev_t         fev;

    sup_rst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (cs_wdi_n),
        .fall_o (kick)
    );

    sup_rst_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .run_i  (running),
        .clr_i  (kick),
        .tick_o (tick)
    );

    sup_rst_wdog #(
        .TMO_SHORT (TMO_SHORT),
        .TMO_MED   (TMO_MED),
        .TMO_LONG  (TMO_LONG),
        .CW        (CNT_W)
    ) u_wd (
        .clk      (clk),
        .rst      (rst),
        .run_i    (running),
        .kick_i   (kick),
        .tick_i   (tick),
        .sel_i    (wd_sel),
        .expire_o (wd_expire),
        .cnt_o    (wd_cnt)
    );

    assign fev.wd_hit = wd_expire;
    assign fev.set    = flag_set;
    assign fev.clr    = flag_clr;

    sup_rst_hold_ctrl #(
        .POR_HOLD  (POR_HOLD),
        .LV_SETTLE (LV_SETTLE),
        .WD_PULSE  (WD_PULSE),
        .HW        (HLD_W)
    ) u_hold (
        .clk          (clk),
        .rst          (rst),
        .supply_low_i (supply_low),
        .ev_i         (fev),
        .run_o        (running),
        .flag_o       (wd_flag)
    );

    assign reset_out = ~running;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_low,
    input logic [1:0]       wd_sel,
    input logic             flag_set,
    input logic             flag_clr,
    input logic             reset_out,
    input logic             wd_flag,
    input logic             wd_expire,
    input logic [CNT_W-1:0] wd_cnt
);
    AST_POR_STRETCH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> reset_out); // R1

    AST_LOWV_FORCES: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> reset_out); // R4

    AST_EXPIRY_EFFECT: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> (reset_out && wd_flag)); // R3

    AST_OFF_NO_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (wd_sel == 2'b11) |-> !wd_expire); // R5

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
        reset_out |=> (wd_cnt == '0)); // R7

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!flag_set && !flag_clr && !wd_expire) |=> $stable(wd_flag)); // R8

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> wd_flag); // R9
endmodule

bind sup_reset_gen sup_reset_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .wd_sel     (wd_sel),
    .flag_set   (flag_set),
    .flag_clr   (flag_clr),
    .reset_out  (reset_out),
    .wd_flag    (wd_flag),
    .wd_expire  (wd_expire),
    .wd_cnt     (wd_cnt)
);

// File: tb/sup_reset_gen_bench.sv
`timescale 1ns/1ps
module sup_reset_gen_bench;
    localparam int POR_HOLD  = 24;
    localparam int LV_SETTLE = 16;
    localparam int WD_PULSE  = 6;
    localparam int TICK_DIV  = 4;
    localparam int TMO_SHORT = 8;
    localparam int TMO_MED   = 16;
    localparam int TMO_LONG  = 32;
    localparam int BOUND     = 2000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_low = 1'b0;
    logic [1:0] wd_sel = 2'b00;
    logic       cs_wdi_n = 1'b1;
    logic       flag_set = 1'b0;
    logic       flag_clr = 1'b0;
    logic       reset_out;
    logic       wd_flag;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sup_reset_gen #(
        .POR_HOLD (POR_HOLD), .LV_SETTLE (LV_SETTLE), .WD_PULSE (WD_PULSE),
        .TICK_DIV (TICK_DIV), .TMO_SHORT (TMO_SHORT), .TMO_MED (TMO_MED),
        .TMO_LONG (TMO_LONG), .SYNC_STAGES (2)
    ) u_sup_reset_gen (
        .clk (clk), .rst (rst), .supply_low (supply_low), .wd_sel (wd_sel),
        .cs_wdi_n (cs_wdi_n), .flag_set (flag_set), .flag_clr (flag_clr),
        .reset_out (reset_out), .wd_flag (wd_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // Count samples while reset_out stays high, current sample included
    task automatic count_high(output int n);
        n = 0;
        while (reset_out && n < BOUND) begin n++; step(); end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!reset_out && n < BOUND) begin n++; step(); end
    endtask

    // Power-on pulse; returns the measured stretch, ends at first low sample
    task automatic do_por(output int n);
        @(negedge clk);
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        count_high(n);
    endtask

    task automatic t_por();
        int n;
        @(negedge clk);
        rst = 1'b1;
        step(); step();
        check(reset_out == 1'b1, "R1 reset during rst", reset_out, 1);
        check(wd_flag == 1'b0, "R1 flag cleared by rst", wd_flag, 0);
        rst = 1'b0;
        count_high(n);
        check(n == POR_HOLD, "R1 power-on stretch", n, POR_HOLD);
    endtask

    task automatic t_timeout(input logic [1:0] sel, input int tmo);
        int n;
        wd_sel = sel;
        do_por(n);
        count_low(n);
        check(n == tmo * TICK_DIV, "R2 timeout length", n, tmo * TICK_DIV);
        check(wd_flag == 1'b1, "R8 flag after expiry", wd_flag, 1);
        count_high(n);
        check(n == WD_PULSE, "R3 watchdog pulse width", n, WD_PULSE);
        count_low(n);
        check(n == tmo * TICK_DIV, "R7 full interval after watchdog reset", n, tmo * TICK_DIV);
    endtask

    task automatic t_disabled();
        int n;
        int seen;
        wd_sel = 2'b11;
        do_por(n);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            if (reset_out) seen++;
            step();
        end
        check(seen == 0, "R5 no expiry when off", seen, 0);
        wd_sel = 2'b00;
        count_low(n);
        check(n <= (TMO_SHORT + 1) * TICK_DIV && n > 0, "R5 re-armed", n, TMO_SHORT * TICK_DIV);
    endtask

    task automatic t_kick();
        int n;
        int seen;
        wd_sel = 2'b00;
        do_por(n);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            cs_wdi_n = 1'b0;
            for (int i = 0; i < 2; i++) begin if (reset_out) seen++; step(); end
            cs_wdi_n = 1'b1;
            for (int i = 0; i < 18; i++) begin if (reset_out) seen++; step(); end
        end
        check(seen == 0, "R6 falling edges keep alive", seen, 0);
        // Rising edge alone: hold line low through power-on, raise at release
        cs_wdi_n = 1'b0;
        do_por(n);
        cs_wdi_n = 1'b1;
        count_low(n);
        check(n == TMO_SHORT * TICK_DIV, "R6 rising edge does not restart", n, TMO_SHORT * TICK_DIV);
        count_high(n);
    endtask

    task automatic t_lowv();
        int n;
        wd_sel = 2'b00;
        do_por(n);
        flag_set = 1'b1;
        step();
        flag_set = 1'b0;
        for (int i = 0; i < 5; i++) step();
        supply_low = 1'b1;
        step();
        check(reset_out == 1'b1, "R4 supply low asserts reset", reset_out, 1);
        for (int i = 0; i < 40; i++) step();
        check(reset_out == 1'b1, "R4 reset held while supply low", reset_out, 1);
        supply_low = 1'b0;
        count_high(n);
        check(n == LV_SETTLE, "R4 settle period", n, LV_SETTLE);
        check(wd_flag == 1'b1, "R8 flag kept across supply reset", wd_flag, 1);
        count_low(n);
        check(n == TMO_SHORT * TICK_DIV, "R7 full interval after supply reset", n, TMO_SHORT * TICK_DIV);
        count_high(n);
    endtask

    task automatic t_flag();
        int n;
        wd_sel = 2'b11;
        do_por(n);
        check(wd_flag == 1'b0, "R9 flag starts clear", wd_flag, 0);
        flag_set = 1'b1; step(); flag_set = 1'b0;
        check(wd_flag == 1'b1, "R9 set command", wd_flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check(wd_flag == 1'b0, "R9 clear command", wd_flag, 0);
        flag_set = 1'b1; flag_clr = 1'b1; step();
        flag_set = 1'b0; flag_clr = 1'b0;
        check(wd_flag == 1'b1, "R9 set beats clear", wd_flag, 1);
        flag_clr = 1'b1; step();
        wd_sel = 2'b00;
        count_low(n);
        check(wd_flag == 1'b1, "R9 expiry beats clear", wd_flag, 1);
        step();
        check(wd_flag == 1'b0, "R9 clear after expiry", wd_flag, 0);
        flag_clr = 1'b0;
        count_high(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired, all R, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_por();
        t_timeout(2'b00, TMO_SHORT);
        t_timeout(2'b01, TMO_MED);
        t_timeout(2'b10, TMO_LONG);
        t_disabled();
        t_kick();
        t_lowv();
        t_flag();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule